// File: doc/BRIEF.md
# Bus-Master DMA Register Window with Channel Interrupt Merge

This block holds the small byte-wide register window that a host uses to steer bus-master transfers on a two-channel disk controller. Each channel has a command byte and a status byte. The status byte combines three kinds of bit: bits that clear when the host writes a 1 to them, bits that the host may load freely, and bits that only the hardware drives. Interrupt requests from the two drives are tracked here. A drive's request sets the interrupt flag in its channel's status byte, and all requests are merged into one level interrupt line for the host bus.

A static strap selects one of two controller variants. On the plain variant, window offsets 1 and 3 hold nothing. There, the merged line is simply any channel request that is still enabled. On the extended variant, offset 1 holds a shared mode byte, and offset 3 holds a timing byte for each channel. The mode byte shows a pending bit for each channel and a host-writable block bit for each channel. A blocked channel cannot drive the merged line, but its pending bit still shows.

Each channel has a two-state request tracker, `LINE_IDLE` and `LINE_ACTIVE`:
- `LINE_IDLE` to `LINE_ACTIVE`, named *raise*, happens on a clock edge that sees the enabled request high. The enabled request is the drive request AND NOT the drive's interrupt-disable bit. This transition is what sets the status interrupt flag.
- `LINE_ACTIVE` to `LINE_IDLE`, named *drop*, happens on an edge that sees the enabled request low.

Top module: `bmdma_regs`

## Requirements
- R1: After reset, every readable byte reads 0x00 on the extended variant: both command bytes, both status bytes, the mode byte and both timing bytes. `irq_out` is low.
- R2: At offset 0, a write stores all eight bits as the selected channel's command byte, and a read returns that byte.
- R3: A write at offset 2 changes the selected channel's status byte as follows. Bits 6:5 load from the written value. Bit 1 (error) and bit 2 (interrupt) clear wherever the written bit is 1. Bit 0 (transfer active) keeps its value. Bits 7, 4 and 3 always read 0.
- R4: Status bit 2 of a channel sets on the edge where that channel's tracker takes the *raise* transition. When a clearing write to that bit falls on the same edge, the set wins.
- R5: With `mode_regs_en` low, reads at offsets 1 and 3 return 0xFF. Writes at those offsets change neither the mode byte's block bits nor the timing bytes, so the values seen after a later switch to the extended variant are the same as before.
- R6: With `mode_regs_en` high, offset 1 reads the mode byte for either channel: bit 2 is channel 0 pending, bit 3 is channel 1 pending, bit 4 is channel 0 block, bit 5 is channel 1 block, and all other bits are 0. A write there loads only bits 5:4.
- R7: With `mode_regs_en` high, offset 3 reads and writes a timing byte, a separate byte for each channel, chosen by `chan_sel`.
- R8: A channel's pending bit is high exactly when that channel's tracker is in `LINE_ACTIVE`. It therefore equals the enabled request sampled at the previous clock edge, and a disabled request never becomes pending.
- R9: On the extended variant, `irq_out` = (pending0 AND NOT block0) OR (pending1 AND NOT block1). On the plain variant, `irq_out` = pending0 OR pending1, whatever the block bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_regs_en | input | 1 | Variant strap: 1 means the mode byte and timing bytes exist |
| chan_sel | input | 1 | Channel addressed by the window access |
| reg_off | input | 2 | Byte offset in the window: 0 command, 1 mode, 2 status, 3 timing |
| wr_en | input | 1 | Write strobe for the addressed byte |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the addressed byte (combinational) |
| dev_irq | input | 2 | Interrupt request from each channel's drive |
| irq_disable | input | 2 | Interrupt-disable bit of each channel's drive |
| irq_out | output | 1 | Merged level interrupt to the host bus |

## Verification
A tracker in the wrong state shows up one cycle after the request changes. It appears as a wrong pending bit in the mode byte and a wrong `irq_out` level, and it appears as a missing or extra status interrupt flag on that edge. A lost write-1-to-clear or a wrongly loaded status field is visible on the next read of offset 2. A block bit changed by a plain-variant write stays hidden until the strap returns high. The bench therefore re-reads the mode byte after every such strap change.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    localparam int unsigned NUM_CH = 2;

    // window offsets
    typedef enum logic [1:0] {
        OFF_CMD    = 2'd0,
        OFF_MODE   = 2'd1,
        OFF_STAT   = 2'd2,
        OFF_TIMING = 2'd3
    } reg_off_e;

    // request tracker per channel
    typedef enum logic {
        LINE_IDLE   = 1'b0,
        LINE_ACTIVE = 1'b1
    } line_state_e;

    // status byte bit positions
    localparam int unsigned ST_ACT    = 0;
    localparam int unsigned ST_ERR    = 1;
    localparam int unsigned ST_INT    = 2;
    localparam int unsigned ST_CAP_LO = 5;
    localparam int unsigned ST_CAP_HI = 6;

    // mode byte bit positions (channel index added)
    localparam int unsigned MODE_PEND_LO = 2;
    localparam int unsigned MODE_BLK_LO  = 4;

endpackage

// File: rtl/bmdma_line_fsm.sv
module bmdma_line_fsm
    import bmdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dev_req,
    input  logic req_disable,
    output logic pending,
    output logic raise
);

    line_state_e state_q, state_d;
    logic        req_en;

    assign req_en = dev_req & ~req_disable;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_IDLE:   if (req_en)  state_d = LINE_ACTIVE;
            LINE_ACTIVE: if (!req_en) state_d = LINE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LINE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pending = 1'b0;
        raise   = 1'b0;
        unique case (state_q)
            LINE_IDLE:   raise   = req_en;
            LINE_ACTIVE: pending = 1'b1;
        endcase
    end

endmodule

// File: rtl/bmdma_chan_regs.sv
module bmdma_chan_regs
    import bmdma_pkg::*;
#(
    parameter int unsigned       BYTE_W     = 8,
    parameter logic [BYTE_W-1:0] TIMING_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic              wr_stat,
    input  logic              wr_timing,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              raise,
    output logic [BYTE_W-1:0] cmd_q,
    output logic [BYTE_W-1:0] stat_q,
    output logic [BYTE_W-1:0] timing_q
);

    logic [BYTE_W-1:0] stat_d;

    always_comb begin
        stat_d = stat_q;
        if (wr_stat) begin
            stat_d[ST_CAP_HI:ST_CAP_LO] = wr_data[ST_CAP_HI:ST_CAP_LO];
            if (wr_data[ST_ERR]) stat_d[ST_ERR] = 1'b0;
            if (wr_data[ST_INT]) stat_d[ST_INT] = 1'b0;
        end
        // hardware set takes priority over a host clear
        if (raise) stat_d[ST_INT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            stat_q   <= '0;
            timing_q <= TIMING_RST;
        end else begin
            stat_q <= stat_d;
            if (wr_cmd)    cmd_q    <= wr_data;
            if (wr_timing) timing_q <= wr_data;
        end
    end

endmodule

// File: rtl/bmdma_irq_merge.sv
module bmdma_irq_merge
    import bmdma_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_regs_en,
    input  logic              wr_mode,
    input  logic [NUM_CH-1:0] blk_wdata,
    input  logic [NUM_CH-1:0] pend,
    output logic [BYTE_W-1:0] mode_byte,
    output logic              irq_out
);

    logic [NUM_CH-1:0] blk_q;
    logic              any_raw, any_gated;

    always_ff @(posedge clk) begin
        if (!rst_n)       blk_q <= '0;
        else if (wr_mode) blk_q <= blk_wdata;
    end

    always_comb begin
        mode_byte = '0;
        any_raw   = 1'b0;
        any_gated = 1'b0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            mode_byte[MODE_PEND_LO + ch] = pend[ch];
            mode_byte[MODE_BLK_LO + ch]  = blk_q[ch];
            any_raw   = any_raw | pend[ch];
            any_gated = any_gated | (pend[ch] & ~blk_q[ch]);
        end
        irq_out = mode_regs_en ? any_gated : any_raw;
    end

endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int unsigned       BYTE_W     = 8,
    parameter logic [BYTE_W-1:0] TIMING_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_regs_en,
    input  logic              chan_sel,
    input  logic [1:0]        reg_off,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [NUM_CH-1:0] dev_irq,
    input  logic [NUM_CH-1:0] irq_disable,
    output logic              irq_out
);

    logic [BYTE_W-1:0] cmd_q    [NUM_CH];
    logic [BYTE_W-1:0] stat_q   [NUM_CH];
    logic [BYTE_W-1:0] timing_q [NUM_CH];
    logic [NUM_CH-1:0] pend;
    logic [NUM_CH-1:0] raise;
    logic [BYTE_W-1:0] mode_byte;
    reg_off_e          off;
    logic              wr_mode;

    assign off     = reg_off_e'(reg_off);
    assign wr_mode = wr_en && mode_regs_en && (off == OFF_MODE);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        localparam logic CH_ID = 1'(ch);
        logic sel;
        assign sel = wr_en && (chan_sel == CH_ID);

        bmdma_line_fsm u_line (
            .clk         (clk),
            .rst_n       (rst_n),
            .dev_req     (dev_irq[ch]),
            .req_disable (irq_disable[ch]),
            .pending     (pend[ch]),
            .raise       (raise[ch])
        );

        bmdma_chan_regs #(
            .BYTE_W     (BYTE_W),
            .TIMING_RST (TIMING_RST)
        ) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_cmd    (sel && off == OFF_CMD),
            .wr_stat   (sel && off == OFF_STAT),
            .wr_timing (sel && mode_regs_en && off == OFF_TIMING),
            .wr_data   (wr_data),
            .raise     (raise[ch]),
            .cmd_q     (cmd_q[ch]),
            .stat_q    (stat_q[ch]),
            .timing_q  (timing_q[ch])
        );
    end

    bmdma_irq_merge #(
        .BYTE_W (BYTE_W)
    ) u_merge (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_regs_en (mode_regs_en),
        .wr_mode      (wr_mode),
        .blk_wdata    (wr_data[MODE_BLK_LO +: NUM_CH]),
        .pend         (pend),
        .mode_byte    (mode_byte),
        .irq_out      (irq_out)
    );

    always_comb begin
        rd_data = '0;
        unique case (off)
            OFF_CMD:    rd_data = cmd_q[chan_sel];
            OFF_STAT:   rd_data = stat_q[chan_sel];
            OFF_MODE:   rd_data = mode_regs_en ? mode_byte : '1;
            OFF_TIMING: rd_data = mode_regs_en ? timing_q[chan_sel] : '1;
        endcase
    end

endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_regs_en,
    input logic       chan_sel,
    input logic [1:0] reg_off,
    input logic       wr_en,
    input logic [1:0] cap_wdata,
    input logic [7:0] rd_data,
    input logic [1:0] dev_irq,
    input logic [1:0] irq_disable,
    input logic       irq_out
);

    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R3
    status_load_chk: assert property (@(posedge clk) disable iff (!rst_n || age == 2'd0)
        ($past(wr_en && reg_off == 2'd2) && chan_sel == $past(chan_sel) && reg_off == 2'd2)
        |-> (rd_data[6:5] == $past(cap_wdata) && rd_data[4:3] == 2'b00 && !rd_data[7]));

    // R4
    status_set_chk: assert property (@(posedge clk) disable iff (!rst_n || age < 2'd2)
        ($past(dev_irq[0] & ~irq_disable[0]) && !$past(dev_irq[0] & ~irq_disable[0], 2)
         && chan_sel == 1'b0 && reg_off == 2'd2)
        |-> rd_data[2]);

    // R5
    plain_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_regs_en && reg_off[0]) |-> (rd_data == 8'hFF));

    // R8
    mode_pend_chk: assert property (@(posedge clk) disable iff (!rst_n || age == 2'd0)
        (mode_regs_en && reg_off == 2'd1)
        |-> (rd_data[3:2] == $past(dev_irq & ~irq_disable)));

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n || age == 2'd0)
        irq_out |-> (|$past(dev_irq & ~irq_disable)));

endmodule

bind bmdma_regs bmdma_regs_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_regs_en (mode_regs_en),
    .chan_sel     (chan_sel),
    .reg_off      (reg_off),
    .wr_en        (wr_en),
    .cap_wdata    (wr_data[6:5]),
    .rd_data      (rd_data),
    .dev_irq      (dev_irq),
    .irq_disable  (irq_disable),
    .irq_out      (irq_out)
);

// File: tb/bmdma_regs_tb.sv
`timescale 1ns/1ps
module bmdma_regs_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_regs_en = 1'b1;
    logic       chan_sel = 1'b0;
    logic [1:0] reg_off = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [1:0] dev_irq = 2'b00;
    logic [1:0] irq_disable = 2'b00;
    logic       irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [7:0] m_cmd [2];
    logic [7:0] m_st  [2];
    logic [7:0] m_tim [2];
    logic [1:0] m_blk;
    logic [1:0] m_pend;

    always #2.5 clk = ~clk;

    bmdma_regs u_dut (
        .clk(clk), .rst_n(rst_n), .mode_regs_en(mode_regs_en),
        .chan_sel(chan_sel), .reg_off(reg_off), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .dev_irq(dev_irq),
        .irq_disable(irq_disable), .irq_out(irq_out)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(logic ch, logic [1:0] off);
        case (off)
            2'd0: return m_cmd[ch];
            2'd2: return m_st[ch];
            2'd1: return mode_regs_en ? {2'b00, m_blk, m_pend, 2'b00} : 8'hFF;
            default: return mode_regs_en ? m_tim[ch] : 8'hFF;
        endcase
    endfunction

    function automatic logic exp_irq();
        return mode_regs_en ? |(m_pend & ~m_blk) : |m_pend;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_cmd[c] = 8'h00; m_st[c] = 8'h00; m_tim[c] = 8'h00;
        end
        m_blk = 2'b00; m_pend = 2'b00;
    endtask

    // apply one clock edge to the model and the design
    task automatic tick();
        logic [1:0] en;
        en = dev_irq & ~irq_disable;
        for (int c = 0; c < 2; c++) begin
            logic hit;
            hit = wr_en && (chan_sel == c[0]);
            if (hit && reg_off == 2'd0) m_cmd[c] = wr_data;
            if (hit && reg_off == 2'd3 && mode_regs_en) m_tim[c] = wr_data;
            if (hit && reg_off == 2'd2) begin
                m_st[c][6:5] = wr_data[6:5];
                if (wr_data[1]) m_st[c][1] = 1'b0;
                if (wr_data[2]) m_st[c][2] = 1'b0;
            end
            if (en[c] && !m_pend[c]) m_st[c][2] = 1'b1;
        end
        if (wr_en && reg_off == 2'd1 && mode_regs_en) m_blk = wr_data[5:4];
        m_pend = en;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic write(logic ch, logic [1:0] off, logic [7:0] d);
        chan_sel = ch; reg_off = off; wr_data = d; wr_en = 1'b1;
        tick();
    endtask

    task automatic peek(logic ch, logic [1:0] off, output logic [7:0] v);
        chan_sel = ch; reg_off = off;
        #0.2;
        v = rd_data;
    endtask

    task automatic check_all();
        logic [7:0] v;
        for (int c = 0; c < 2; c++) begin
            for (int o = 0; o < 4; o++) begin
                string req;
                case (o)
                    0: req = "R2";
                    1: req = mode_regs_en ? "R6" : "R5";
                    2: req = "R3";
                    default: req = mode_regs_en ? "R7" : "R5";
                endcase
                peek(c[0], o[1:0], v);
                chk(req, v, exp_read(c[0], o[1:0]));
            end
        end
        chk("R9", {7'd0, irq_out}, {7'd0, exp_irq()});
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int c = 0; c < 2; c++)
            for (int o = 0; o < 4; o++) begin
                peek(c[0], o[1:0], v);
                chk("R1", v, 8'h00);
            end
        chk("R1", {7'd0, irq_out}, 8'h00);

        // R2 command bytes per channel
        write(1'b0, 2'd0, 8'hA5);
        write(1'b1, 2'd0, 8'h3C);
        peek(1'b0, 2'd0, v); chk("R2", v, 8'hA5);
        peek(1'b1, 2'd0, v); chk("R2", v, 8'h3C);

        // R3 status: load 6:5, reserved bits stay 0
        write(1'b0, 2'd2, 8'hFF);
        peek(1'b0, 2'd2, v); chk("R3", v, 8'h60);

        // R4/R8 raise on channel 1
        dev_irq = 2'b10;
        tick();
        peek(1'b1, 2'd2, v); chk("R4", v, 8'h04);
        peek(1'b0, 2'd1, v); chk("R8", v, 8'h08);
        chk("R9", {7'd0, irq_out}, 8'h01);
        // write-1-to-clear while request still held: no new raise
        write(1'b1, 2'd2, 8'h04);
        peek(1'b1, 2'd2, v); chk("R3", v, 8'h00);
        dev_irq = 2'b00;
        tick();
        peek(1'b0, 2'd1, v); chk("R8", v, 8'h00);
        chk("R9", {7'd0, irq_out}, 8'h00);

        // R4 set wins over same-edge clear on channel 0
        dev_irq = 2'b01;
        write(1'b0, 2'd2, 8'h04);
        peek(1'b0, 2'd2, v); chk("R4", v, 8'h04);
        dev_irq = 2'b00;
        tick();

        // R8 disabled request never pends
        dev_irq = 2'b01; irq_disable = 2'b01;
        tick(); tick();
        peek(1'b0, 2'd1, v); chk("R8", v, 8'h00);
        chk("R9", {7'd0, irq_out}, 8'h00);
        irq_disable = 2'b00;
        tick();

        // R6/R9 block bit masks channel 0, pend still visible
        write(1'b1, 2'd1, 8'hDF);
        peek(1'b1, 2'd1, v); chk("R6", v, 8'h14);
        chk("R9", {7'd0, irq_out}, 8'h00);

        // R7 timing bytes
        write(1'b0, 2'd3, 8'h5A);
        write(1'b1, 2'd3, 8'hC3);
        peek(1'b0, 2'd3, v); chk("R7", v, 8'h5A);
        peek(1'b1, 2'd3, v); chk("R7", v, 8'hC3);

        // R5 plain variant: FF reads, writes ignored, block ignored
        mode_regs_en = 1'b0;
        #0.2;
        chk("R9", {7'd0, irq_out}, 8'h01);
        peek(1'b0, 2'd1, v); chk("R5", v, 8'hFF);
        peek(1'b1, 2'd3, v); chk("R5", v, 8'hFF);
        write(1'b0, 2'd1, 8'h00);
        write(1'b0, 2'd3, 8'h00);
        mode_regs_en = 1'b1;
        peek(1'b0, 2'd1, v); chk("R5", v, 8'h14);
        peek(1'b0, 2'd3, v); chk("R5", v, 8'h5A);
        check_all();

        // random phases, strap alternating
        for (int ph = 0; ph < 4; ph++) begin
            mode_regs_en = ph[0];
            for (int i = 0; i < 300; i++) begin
                chan_sel    = $urandom_range(0, 1);
                reg_off     = 2'($urandom_range(0, 3));
                wr_data     = 8'($urandom);
                wr_en       = ($urandom_range(0, 1) == 1);
                dev_irq     = 2'($urandom);
                irq_disable = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00;
                tick();
                check_all();
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule